// File: doc/BRIEF.md
# Ranked Frequent-Value Table Trainer

This block learns which data words occur most often in a stream of observed accesses. It keeps a small ordered table. Each slot holds a word, a valid flag and a narrow occurrence counter. Slot 0 is the top rank. While training is open, each observed word either raises the counter of the slot that already holds it, or is written into the table.

When a counter overflows, its slot moves up one rank by swapping with its upper neighbour. Words seen often therefore drift toward the top.

A cycle timer closes training after a fixed number of clock edges. From then on the table is frozen. A codec can use it through an index read port and a content search port. The search port reports no match at all while training is still open.

Top module: `fvt_trainer`

## Requirements
- R1: After reset, slot 0 is valid with word 0 and count 0, and every other slot is invalid. Slot 0 is the top rank and slot DEPTH-1 is the bottom rank.
- R2: While training, an observed word that matches a valid slot whose count is below its maximum (2^CNT_W-1) raises that count by one, with no other change. The new count is visible on the read port after the same clock edge.
- R3: While training, a match on a slot i>0 whose count is at its maximum swaps slots i and i-1. The matched word moves to slot i-1 with count 0, and the displaced entry moves to slot i with its word, valid flag and count unchanged.
- R4: While training, a match on slot 0 whose count is at its maximum sets that count to 0 and leaves every slot in place.
- R5: While training, an observed word found in no valid slot is written, with count 0, into the invalid slot that has the highest index, when any slot is invalid.
- R6: While training, an observed word found in no valid slot, with every slot valid, replaces slot DEPTH-1 with that word and count 0.
- R7: `done` is low for the first TRAIN_CYCLES-1 clock edges after reset is released and goes high on edge TRAIN_CYCLES. An observation taken on that edge is still applied. `done` then stays high until reset.
- R8: Once `done` is high, observed words change no slot.
- R9: `srch_hit` stays low while `done` is low. Once `done` is high, `srch_hit` is high exactly when a valid slot holds `srch_word`, and `srch_idx` then gives that slot's index.
- R10: A cycle with `obs_valid` low changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| obs_valid | input | 1 | An observed word is present this cycle |
| obs_word | input | WORD_W | Observed word |
| rd_idx | input | IDX_W | Slot index to read |
| rd_value | output | WORD_W | Word stored in the addressed slot |
| rd_valid | output | 1 | Valid flag of the addressed slot |
| rd_count | output | CNT_W | Occurrence counter of the addressed slot |
| srch_word | input | WORD_W | Word to search for |
| srch_hit | output | 1 | Search found the word in a valid slot (after training only) |
| srch_idx | output | IDX_W | Index of the matching slot |
| done | output | 1 | Training has ended and the table is frozen |

## Verification
The freeze edge and an ordinary table update can land on the same clock edge. The bench waits until exactly TRAIN_CYCLES-1 edges have passed. It then presents a new word that must evict the bottom slot on the same edge that raises `done`. The next word must be ignored.

A promotion swap also moves the displaced entry down in that cycle. The bench therefore checks both slots of every swap, including the counter that the displaced entry carries with it. The judgement comes from a bench-side table model that is updated only when the edge index shows that training was still open.

// File: rtl/fvt_pkg.sv
// Package: shared types for the frequent-value trainer.
// Assumes nothing beyond IEEE 1800-2017.
package fvt_pkg;

    // Kind of table update chosen in a cycle
    typedef enum logic [2:0] {
        UPD_NONE    = 3'd0,
        UPD_COUNT   = 3'd1,
        UPD_PROMOTE = 3'd2,
        UPD_TOPRST  = 3'd3,
        UPD_FILL    = 3'd4,
        UPD_EVICT   = 3'd5
    } upd_kind_e;

endpackage

// File: rtl/fvt_match.sv
// fvt_match: parallel compare of a key against every valid slot.
// Reports whether any valid slot holds the key, and the lowest matching index.
// Assumes slot values are unique among valid slots (the trainer keeps them so).
module fvt_match #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 8,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic [WORD_W-1:0]             key,
    input  logic [DEPTH-1:0][WORD_W-1:0]  vals,
    input  logic [DEPTH-1:0]              vlds,
    output logic                          hit,
    output logic [IDX_W-1:0]              idx
);

    logic [DEPTH-1:0] eq;

    // one comparator per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = vlds[g] && (vals[g] == key);
    end

    // priority encode: lowest index wins
    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/fvt_free_pick.sv
// fvt_free_pick: finds the invalid slot with the highest index (lowest rank).
// Assumes DEPTH >= 2.
module fvt_free_pick #(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] vlds,
    output logic             any_free,
    output logic [IDX_W-1:0] free_idx
);

    // scan upward; the last invalid slot seen wins
    always_comb begin
        any_free = ~&vlds;
        free_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!vlds[i]) free_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/fvt_timer.sv
// fvt_timer: counts clock edges after reset and raises a sticky done flag
// on edge TRAIN_CYCLES. Assumes TRAIN_CYCLES >= 1.
module fvt_timer #(
    parameter int TRAIN_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);

    localparam int TW = $clog2(TRAIN_CYCLES + 1);

    logic [TW-1:0] cyc_q;

    // advance the edge count until the window closes, then hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
            done  <= 1'b0;
        end else if (!done) begin
            cyc_q <= cyc_q + TW'(1);
            if (cyc_q == TW'(TRAIN_CYCLES - 1)) done <= 1'b1;
        end
    end

endmodule

// File: rtl/fvt_trainer.sv
// fvt_trainer: ranked frequent-value table with a training window.
// One observed word per cycle; the lookup and its update finish in that cycle.
// After the window closes the table is read-only, and it can be read by index
// or searched by content. Assumes DEPTH >= 2 and CNT_W >= 1.
module fvt_trainer
    import fvt_pkg::*;
#(
    parameter int WORD_W       = 32,
    parameter int DEPTH        = 8,
    parameter int CNT_W        = 4,
    parameter int TRAIN_CYCLES = 100000,
    parameter int IDX_W        = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              obs_valid,
    input  logic [WORD_W-1:0] obs_word,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_value,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  rd_count,
    input  logic [WORD_W-1:0] srch_word,
    output logic              srch_hit,
    output logic [IDX_W-1:0]  srch_idx,
    output logic              done
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [IDX_W-1:0] BOT_IDX = IDX_W'(DEPTH - 1);

    logic [DEPTH-1:0][WORD_W-1:0] val_q, val_d;
    logic [DEPTH-1:0]             vld_q, vld_d;
    logic [DEPTH-1:0][CNT_W-1:0]  cnt_q, cnt_d;

    logic             obs_hit, any_free, s_hit;
    logic [IDX_W-1:0] obs_idx, free_idx, s_idx, up_idx, tgt_idx;
    upd_kind_e        upd;

    fvt_timer #(.TRAIN_CYCLES(TRAIN_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (done)
    );

    fvt_match #(.WORD_W(WORD_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_obs_match (
        .key  (obs_word),
        .vals (val_q),
        .vlds (vld_q),
        .hit  (obs_hit),
        .idx  (obs_idx)
    );

    fvt_match #(.WORD_W(WORD_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_srch_match (
        .key  (srch_word),
        .vals (val_q),
        .vlds (vld_q),
        .hit  (s_hit),
        .idx  (s_idx)
    );

    fvt_free_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_free (
        .vlds     (vld_q),
        .any_free (any_free),
        .free_idx (free_idx)
    );

    // classify this cycle's update
    always_comb begin
        upd = UPD_NONE;
        if (obs_valid && !done) begin
            if (obs_hit) begin
                if (cnt_q[obs_idx] != CNT_MAX)  upd = UPD_COUNT;
                else if (obs_idx == '0)         upd = UPD_TOPRST;
                else                            upd = UPD_PROMOTE;
            end else begin
                upd = any_free ? UPD_FILL : UPD_EVICT;
            end
        end
    end

    assign up_idx  = obs_idx - IDX_W'(1);
    assign tgt_idx = (upd == UPD_FILL) ? free_idx : BOT_IDX;

    // next-state of the table
    always_comb begin
        val_d = val_q;
        vld_d = vld_q;
        cnt_d = cnt_q;
        unique case (upd)
            UPD_COUNT: cnt_d[obs_idx] = cnt_q[obs_idx] + CNT_W'(1);
            UPD_TOPRST: cnt_d[obs_idx] = '0;
            UPD_PROMOTE: begin
                val_d[up_idx]  = val_q[obs_idx];
                vld_d[up_idx]  = 1'b1;
                cnt_d[up_idx]  = '0;
                val_d[obs_idx] = val_q[up_idx];
                vld_d[obs_idx] = vld_q[up_idx];
                cnt_d[obs_idx] = cnt_q[up_idx];
            end
            UPD_FILL, UPD_EVICT: begin
                val_d[tgt_idx] = obs_word;
                vld_d[tgt_idx] = 1'b1;
                cnt_d[tgt_idx] = '0;
            end
            default: ;
        endcase
    end

    // table registers; reset seeds slot 0 with the value zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            vld_q <= DEPTH'(1);
            cnt_q <= '0;
        end else begin
            val_q <= val_d;
            vld_q <= vld_d;
            cnt_q <= cnt_d;
        end
    end

    // index read port
    always_comb begin
        rd_value = '0;
        rd_valid = 1'b0;
        rd_count = '0;
        if (32'(rd_idx) < DEPTH) begin
            rd_value = val_q[rd_idx];
            rd_valid = vld_q[rd_idx];
            rd_count = cnt_q[rd_idx];
        end
    end

    // content search is gated off until training ends
    assign srch_hit = done && s_hit;
    assign srch_idx = s_idx;

endmodule

// File: rtl/fvt_trainer_chk.sv
// fvt_trainer_chk: temporal checks on the trainer, attached by bind.
// Assumes the synchronous active-low reset is held for at least one edge.
module fvt_trainer_chk #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          done,
    input logic                          obs_valid,
    input logic                          srch_hit,
    input logic [DEPTH-1:0][WORD_W-1:0]  val,
    input logic [DEPTH-1:0]              vld,
    input logic [DEPTH-1:0][CNT_W-1:0]   cnt
);

    // R1
    reset_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (vld == DEPTH'(1)) && (val[0] == '0) && (cnt[0] == '0));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R8
    frozen_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(val) && $stable(vld) && $stable(cnt)));

    // R9
    search_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !srch_hit);

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !obs_valid |=> ($stable(val) && $stable(vld) && $stable(cnt)));

    // R5
    fill_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(vld) >= $countones($past(vld))));

endmodule

bind fvt_trainer fvt_trainer_chk #(
    .WORD_W (WORD_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .obs_valid (obs_valid),
    .srch_hit  (srch_hit),
    .val       (val_q),
    .vld       (vld_q),
    .cnt       (cnt_q)
);

// File: tb/fvt_trainer_bench.sv
// Scoreboard bench: driver tasks push expected items, a monitor pops and compares.
module fvt_trainer_bench;

    localparam int WORD_W = 16;
    localparam int DEPTH  = 4;
    localparam int CNT_W  = 2;
    localparam int TRAIN  = 200;
    localparam int IDX_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              obs_valid = 1'b0;
    logic [WORD_W-1:0] obs_word = '0;
    logic [IDX_W-1:0]  rd_idx = '0;
    logic [WORD_W-1:0] rd_value;
    logic              rd_valid;
    logic [CNT_W-1:0]  rd_count;
    logic [WORD_W-1:0] srch_word = '0;
    logic              srch_hit;
    logic [IDX_W-1:0]  srch_idx;
    logic              done;

    always #10 clk = ~clk;

    fvt_trainer #(
        .WORD_W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .TRAIN_CYCLES(TRAIN)
    ) u_fvt_trainer (
        .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_word(obs_word),
        .rd_idx(rd_idx), .rd_value(rd_value), .rd_valid(rd_valid), .rd_count(rd_count),
        .srch_word(srch_word), .srch_hit(srch_hit), .srch_idx(srch_idx), .done(done)
    );

    typedef struct {
        int                kind;   // 0 slot read, 1 search, 2 done flag
        int                idx;
        logic [WORD_W-1:0] word;
        logic              flag;
        logic [CNT_W-1:0]  cnt;
        string             req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails  = 0;
    int ecnt   = 0;

    logic [WORD_W-1:0] m_val [DEPTH];
    logic              m_vld [DEPTH];
    logic [CNT_W-1:0]  m_cnt [DEPTH];

    // edges since reset release
    always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

    // monitor: pop each expected item and compare at the ports
    initial begin
        forever begin
            wait (q.size() > 0);
            begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (it.kind == 0) begin
                    rd_idx = IDX_W'(it.idx);
                    #1;
                    if (rd_valid !== it.flag ||
                        (it.flag && (rd_value !== it.word || rd_count !== it.cnt)))
                        begin
                        fails++;
                        $display("FAIL %s slot %0d: got v=%b w=%h c=%0d, exp v=%b w=%h c=%0d",
                                 it.req, it.idx, rd_valid, rd_value, rd_count,
                                 it.flag, it.word, it.cnt);
                    end
                end else if (it.kind == 1) begin
                    srch_word = it.word;
                    #1;
                    if (srch_hit !== it.flag || (it.flag && srch_idx !== IDX_W'(it.idx))) begin
                        fails++;
                        $display("FAIL %s search %h: got hit=%b idx=%0d, exp hit=%b idx=%0d",
                                 it.req, it.word, srch_hit, srch_idx, it.flag, it.idx);
                    end
                end else begin
                    #1;
                    if (done !== it.flag) begin
                        fails++;
                        $display("FAIL %s done: got %b, exp %b", it.req, done, it.flag);
                    end
                end
            end
        end
    end

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) begin
            m_val[i] = '0; m_vld[i] = (i == 0); m_cnt[i] = '0;
        end
    endtask

    task automatic model_apply(input logic [WORD_W-1:0] w);
        int hi = -1;
        int fr = -1;
        for (int i = DEPTH - 1; i >= 0; i--) if (m_vld[i] && m_val[i] == w) hi = i;
        if (hi >= 0) begin
            if (m_cnt[hi] != {CNT_W{1'b1}}) m_cnt[hi] = m_cnt[hi] + 1'b1;
            else if (hi == 0) m_cnt[0] = '0;
            else begin
                m_val[hi] = m_val[hi-1]; m_vld[hi] = m_vld[hi-1]; m_cnt[hi] = m_cnt[hi-1];
                m_val[hi-1] = w; m_vld[hi-1] = 1'b1; m_cnt[hi-1] = '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) if (!m_vld[i]) fr = i;
            if (fr < 0) fr = DEPTH - 1;
            m_val[fr] = w; m_vld[fr] = 1'b1; m_cnt[fr] = '0;
        end
    endtask

    task automatic drain();
        wait (q.size() == 0);
        #2;
    endtask

    task automatic push_table(input string req);
        for (int i = 0; i < DEPTH; i++) begin
            item_t it;
            it.kind = 0; it.idx = i; it.word = m_val[i];
            it.flag = m_vld[i]; it.cnt = m_cnt[i]; it.req = req;
            q.push_back(it);
        end
        drain();
    endtask

    task automatic push_search(input logic [WORD_W-1:0] w, input logic frozen, input string req);
        item_t it;
        it.kind = 1; it.word = w; it.flag = 1'b0; it.idx = 0; it.cnt = '0; it.req = req;
        if (frozen)
            for (int i = DEPTH - 1; i >= 0; i--)
                if (m_vld[i] && m_val[i] == w) begin it.flag = 1'b1; it.idx = i; end
        q.push_back(it);
        drain();
    endtask

    task automatic push_done(input logic exp, input string req);
        item_t it;
        it.kind = 2; it.flag = exp; it.idx = 0; it.word = '0; it.cnt = '0; it.req = req;
        q.push_back(it);
        drain();
    endtask

    // drive one observed word across one edge; model follows if training was open
    task automatic observe(input logic [WORD_W-1:0] w);
        int e;
        @(negedge clk);
        e = ecnt;
        obs_word  = w;
        obs_valid = 1'b1;
        @(posedge clk);
        #1;
        obs_valid = 1'b0;
        if (e < TRAIN) model_apply(w);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hung run, exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        push_table("R1");
        push_search(16'h0000, 1'b0, "R9");

        observe(16'h0000);
        push_table("R2");

        observe(16'h00A1);
        observe(16'h00B2);
        observe(16'h00C3);
        push_table("R5");

        observe(16'h00B2);
        push_table("R2");

        observe(16'h00D4);
        push_table("R6");

        repeat (3) observe(16'h00D4);
        push_table("R2");
        observe(16'h00D4);
        push_table("R3");

        repeat (2) observe(16'h0000);
        observe(16'h0000);
        push_table("R4");

        repeat (5) @(negedge clk);
        push_table("R10");
        push_search(16'h00D4, 1'b0, "R9");

        repeat (4) observe(16'h00C3);
        push_table("R3");

        observe(16'h00E5);
        push_table("R6");

        while (ecnt < TRAIN - 1) @(negedge clk);
        push_done(1'b0, "R7");
        observe(16'h0F0F);
        push_done(1'b1, "R7");
        push_table("R7");

        observe(16'h00F6);
        push_table("R8");
        repeat (3) @(negedge clk);
        push_done(1'b1, "R7");

        push_search(16'h00C3, 1'b1, "R9");
        push_search(16'h0F0F, 1'b1, "R9");
        push_search(16'h00F6, 1'b1, "R9");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule